// File: doc/BRIEF.md
# Configurable asynchronous serial line controller

This block is one asynchronous serial line: a character transmitter, a character receiver, and a small set of modem-control signals. A host reaches it through a 2-bit register-select bus with separate write and read strobes. Two 8-bit control registers set the character format, the bit clocks and the line modes. One 8-bit status register reports errors, modem levels and the state of the data path. A single holding address accepts a character to send when written and returns the last received character when read.

Bit timing comes from single-cycle enable ticks at sixteen times the bit rate. There are four rate inputs and one external tick. The fastest rate can also be divided by 2, 4 or 8 inside the block. The receiver finds each start bit, samples every bit at its middle, and checks both parity and the stop bit. The line can be looped back internally, can send a break, or can echo every received character back out on the line.

Top module: `sla_line_ctrl`

## Requirements
- R1: After an active-low reset, both control registers read 0x00. The status register reads 0x01 while the modem inputs are low. `txd`, `rts_n` and `dtr_n` are all high.
- R2: Register select codes are 0 for control 1, 1 for control 2, 2 for status and 3 for holding. Both control registers read back what was written to them. Control 1 bit 1 set drives `rts_n` low, and control 1 bit 0 set drives `dtr_n` low.
- R3: A transmitted frame is made of the following parts, in order:
  - a low start bit;
  - data bits sent LSB first, with the count set by control 2 bits 7:6 (00 gives 8, 01 gives 7, 10 gives 6, 11 gives 5);
  - an optional parity bit;
  - high stop bits: one when control 1 bit 5 is set, two when it is clear.
- R4: Control 1 bit 3 enables parity. Control 2 bit 4 selects even parity when set and odd parity when clear. The parity is computed over the data bits that are actually sent.
- R5: Status bit 0 (transmit holding empty) is clear right after a holding write. It sets again as soon as the shifter takes the character, while that character is still on the line.
- R6: Control 2 bits 2:0 choose the transmit tick: 000 is the external tick, 001 to 011 are rates 1 to 3, 100 is rate 4, and 101, 110 and 111 are rate 4 divided by 2, 4 and 8. One bit lasts 16 ticks.
- R7: When control 2 bit 3 is set, the receive tick is the transmit tick. When it is clear, the receive tick is rate 1.
- R8: With control 1 bit 2 set, a received character is placed right-aligned in the holding register and sets status bit 1. Reading the holding address returns that character and clears status bit 1.
- R9: The error bits are framing (status bit 4, stop bit sampled low), parity (bit 3) and overrun (bit 2, set when a character completes while bit 1 is still set). They stay set until the status register is read.
- R10: With control 1 bit 7 clear, `txd` holds high and the receiver takes the transmitter output directly.
- R11: With control 1 bits 7 and 6 both set, `txd` is held low (break).
- R12: With control 1 bit 4 set, each received character is loaded into the transmit holding register and sent out again.
- R13: Status bits 6 and 5 show the DSR and CD levels. Status bit 7 sets in two cases: DSR or CD changes while control 1 bit 0 is set, or RI changes while control 1 bit 0 is clear. Reading the status register clears bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| sel | input | 2 | Register select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe (clears read-sensitive flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| rate_tick | input | 4 | Enable ticks for rates 1 to 4 (bit 0 = rate 1) |
| ext_tick | input | 1 | External clock enable tick |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| dsr | input | 1 | Data set ready |
| cd | input | 1 | Carrier detect |
| ri | input | 1 | Ring indicator |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and a two-stage input synchroniser. It drives rate 4 on every clock, rate 1 every third clock and the external tick every second clock. A rate-4 bit therefore takes 16 clocks, so 8-bit, 7-bit and 5-bit frames with parity and two stop bits fit in a few hundred cycles. The same settings make the divide-by-8 and rate-1 bit periods (128 and 48 clocks) short enough to decode directly. The bench decodes the line at mid-bit and checks the loop, break and modem output levels on every clock against a behavioural model of the control register.

// File: rtl/sla_pkg.sv
package sla_pkg;
  localparam logic [1:0] SEL_CTL1 = 2'd0;
  localparam logic [1:0] SEL_CTL2 = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_HOLD = 2'd3;

  // control 1 bit positions
  localparam int C1_NORMAL = 7;
  localparam int C1_BREAK  = 6;
  localparam int C1_ONESTP = 5;
  localparam int C1_ECHO   = 4;
  localparam int C1_PAREN  = 3;
  localparam int C1_RXEN   = 2;
  localparam int C1_RTS    = 1;
  localparam int C1_DTR    = 0;

  // control 2 bit positions
  localparam int C2_EVEN   = 4;
  localparam int C2_RXFOL  = 3;

  // number of divided-down variants of the top rate
  localparam int DIV_STEPS = 3;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_st_e;

  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

  function automatic logic par_calc(input logic [7:0] d, input logic [3:0] n,
                                    input logic even);
    logic [7:0] m;
    m = d & ~(8'hFF << n);
    return even ? (^m) : ~(^m);
  endfunction
endpackage

// File: rtl/sla_tick_sel.sv
module sla_tick_sel
  import sla_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_tick,
  input  logic       ext_tick,
  input  logic [2:0] tx_sel,
  input  logic       rx_follow,
  output logic       tx_tick,
  output logic       rx_tick
);
  logic [DIV_STEPS-1:0] div_cnt, div_cnt_n;
  logic [DIV_STEPS:0]   div_tick;

  assign div_tick[0] = rate_tick[3];
  for (genvar k = 1; k <= DIV_STEPS; k++) begin : g_div
    assign div_tick[k] = rate_tick[3] & (&div_cnt[k-1:0]);
  end

  always_comb begin
    div_cnt_n = div_cnt;
    if (rate_tick[3]) div_cnt_n = div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt_n;
  end

  always_comb begin
    unique case (tx_sel)
      3'd0:    tx_tick = ext_tick;
      3'd1:    tx_tick = rate_tick[0];
      3'd2:    tx_tick = rate_tick[1];
      3'd3:    tx_tick = rate_tick[2];
      3'd4:    tx_tick = div_tick[0];
      3'd5:    tx_tick = div_tick[1];
      3'd6:    tx_tick = div_tick[2];
      default: tx_tick = div_tick[3];
    endcase
  end

  assign rx_tick = rx_follow ? tx_tick : rate_tick[0];
endmodule

// File: rtl/sla_tx.sv
module sla_tx
  import sla_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  input  logic [3:0] nbits,
  input  logic       pen,
  input  logic       even,
  input  logic       one_stop,
  output logic       take,
  output logic       line
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  tx_st_e        st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [2:0]    idx, idx_n;
  logic [7:0]    shr, shr_n;
  logic          par, par_n;
  logic [2:0]    last_idx;

  assign last_idx = 3'(nbits - 4'd1);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    idx_n = idx;
    shr_n = shr;
    par_n = par;
    take  = 1'b0;
    if (st == TX_IDLE) begin
      if (load) begin
        take  = 1'b1;
        st_n  = TX_START;
        cnt_n = '0;
        idx_n = '0;
        shr_n = din;
        par_n = par_calc(din, nbits, even);
      end
    end else if (tick) begin
      if (cnt != LAST) begin
        cnt_n = cnt + 1'b1;
      end else begin
        cnt_n = '0;
        unique case (st)
          TX_START: begin
            st_n  = TX_DATA;
            idx_n = '0;
          end
          TX_DATA: begin
            if (idx == last_idx) begin
              st_n  = pen ? TX_PAR : TX_STOP;
              idx_n = '0;
            end else begin
              idx_n = idx + 1'b1;
            end
          end
          TX_PAR: begin
            st_n  = TX_STOP;
            idx_n = '0;
          end
          TX_STOP: begin
            if (one_stop || idx != 3'd0) st_n = TX_IDLE;
            else                         idx_n = 3'd1;
          end
          default: st_n = TX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= TX_IDLE;
      cnt <= '0;
      idx <= '0;
      shr <= '0;
      par <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      idx <= idx_n;
      shr <= shr_n;
      par <= par_n;
    end
  end

  always_comb begin
    unique case (st)
      TX_START: line = 1'b0;
      TX_DATA:  line = shr[idx];
      TX_PAR:   line = par;
      default:  line = 1'b1;
    endcase
  end
endmodule

// File: rtl/sla_rx.sv
module sla_rx
  import sla_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       line,
  input  logic [3:0] nbits,
  input  logic       pen,
  input  logic       even,
  output logic       done,
  output logic [7:0] dout,
  output logic       perr,
  output logic       ferr
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  rx_st_e        st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [2:0]    idx, idx_n;
  logic [7:0]    shr, shr_n;
  logic          pbit, pbit_n;
  logic          done_n, perr_n, ferr_n;
  logic [2:0]    last_idx;

  assign last_idx = 3'(nbits - 4'd1);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    idx_n  = idx;
    shr_n  = shr;
    pbit_n = pbit;
    done_n = 1'b0;
    perr_n = perr;
    ferr_n = ferr;
    if (!en) begin
      st_n = RX_IDLE;
    end else if (tick) begin
      unique case (st)
        RX_IDLE: begin
          if (!line) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt != MID) begin
            cnt_n = cnt + 1'b1;
          end else if (!line) begin
            st_n  = RX_DATA;
            cnt_n = '0;
            idx_n = '0;
            shr_n = '0;
          end else begin
            st_n = RX_IDLE;
          end
        end
        default: begin
          if (cnt != LAST) begin
            cnt_n = cnt + 1'b1;
          end else begin
            cnt_n = '0;
            if (st == RX_DATA) begin
              shr_n[idx] = line;
              if (idx == last_idx) st_n = pen ? RX_PAR : RX_STOP;
              else                 idx_n = idx + 1'b1;
            end else if (st == RX_PAR) begin
              pbit_n = line;
              st_n   = RX_STOP;
            end else begin
              done_n = 1'b1;
              ferr_n = !line;
              perr_n = pen && (pbit != par_calc(shr, nbits, even));
              st_n   = RX_IDLE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      shr  <= '0;
      pbit <= 1'b0;
      done <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      idx  <= idx_n;
      shr  <= shr_n;
      pbit <= pbit_n;
      done <= done_n;
      perr <= perr_n;
      ferr <= ferr_n;
    end
  end

  assign dout = shr;
endmodule

// File: rtl/sla_modem.sv
module sla_modem #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dsr_i,
  input  logic cd_i,
  input  logic ri_i,
  input  logic dtr_on,
  output logic dsr_q,
  output logic cd_q,
  output logic change
);
  logic [SYNC-1:0] s_dsr, s_cd, s_ri;
  logic [2:0]      prev, cur;

  assign cur = {s_ri[SYNC-1], s_cd[SYNC-1], s_dsr[SYNC-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_dsr <= '0;
      s_cd  <= '0;
      s_ri  <= '0;
      prev  <= '0;
    end else begin
      s_dsr <= {s_dsr[SYNC-2:0], dsr_i};
      s_cd  <= {s_cd[SYNC-2:0], cd_i};
      s_ri  <= {s_ri[SYNC-2:0], ri_i};
      prev  <= cur;
    end
  end

  assign dsr_q  = cur[0];
  assign cd_q   = cur[1];
  assign change = dtr_on ? ((cur[0] ^ prev[0]) | (cur[1] ^ prev[1]))
                         : (cur[2] ^ prev[2]);
endmodule

// File: rtl/sla_line_ctrl.sv
module sla_line_ctrl
  import sla_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [3:0] rate_tick,
  input  logic       ext_tick,
  input  logic       rxd,
  output logic       txd,
  output logic       rts_n,
  output logic       dtr_n,
  input  logic       dsr,
  input  logic       cd,
  input  logic       ri
);
  logic [7:0] ctrl1, ctrl1_n, ctrl2, ctrl2_n;
  logic [7:0] thr, thr_n, rbr, rbr_n;
  logic       thr_full, thr_full_n, rx_full, rx_full_n;
  logic       f_dsc, f_dsc_n, f_fe, f_fe_n, f_pe, f_pe_n, f_ovr, f_ovr_n;
  logic [SYNC-1:0] rx_sync;

  logic       tx_tick, rx_tick, take, tx_line, rx_line, rxd_s;
  logic       rx_done, rx_perr, rx_ferr, dsr_q, cd_q, dsc_evt;
  logic [7:0] rx_data, status;
  logic [3:0] nbits;
  logic       wr_c1, wr_c2, wr_hold, rd_stat, rd_hold, echo_load;

  assign nbits   = char_bits(ctrl2[7:6]);
  assign wr_c1   = wr && sel == SEL_CTL1;
  assign wr_c2   = wr && sel == SEL_CTL2;
  assign wr_hold = wr && sel == SEL_HOLD;
  assign rd_stat = rd && sel == SEL_STAT;
  assign rd_hold = rd && sel == SEL_HOLD;
  assign echo_load = rx_done && ctrl1[C1_ECHO];

  sla_tick_sel u_tick (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .ext_tick(ext_tick),
    .tx_sel(ctrl2[2:0]), .rx_follow(ctrl2[C2_RXFOL]),
    .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  sla_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .load(thr_full), .din(thr),
    .nbits(nbits), .pen(ctrl1[C1_PAREN]), .even(ctrl2[C2_EVEN]),
    .one_stop(ctrl1[C1_ONESTP]), .take(take), .line(tx_line)
  );

  sla_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .en(ctrl1[C1_RXEN]),
    .line(rx_line), .nbits(nbits), .pen(ctrl1[C1_PAREN]),
    .even(ctrl2[C2_EVEN]), .done(rx_done), .dout(rx_data),
    .perr(rx_perr), .ferr(rx_ferr)
  );

  sla_modem #(.SYNC(SYNC)) u_modem (
    .clk(clk), .rst_n(rst_n), .dsr_i(dsr), .cd_i(cd), .ri_i(ri),
    .dtr_on(ctrl1[C1_DTR]), .dsr_q(dsr_q), .cd_q(cd_q), .change(dsc_evt)
  );

  assign rxd_s   = rx_sync[SYNC-1];
  assign rx_line = ctrl1[C1_NORMAL] ? rxd_s : tx_line;
  assign txd     = !ctrl1[C1_NORMAL] ? 1'b1 :
                   (ctrl1[C1_BREAK] ? 1'b0 : tx_line);
  assign rts_n   = !ctrl1[C1_RTS];
  assign dtr_n   = !ctrl1[C1_DTR];

  assign status = {f_dsc, dsr_q, cd_q, f_fe, f_pe, f_ovr, rx_full, !thr_full};

  always_comb begin
    unique case (sel)
      SEL_CTL1: rdata = ctrl1;
      SEL_CTL2: rdata = ctrl2;
      SEL_STAT: rdata = status;
      default:  rdata = rbr;
    endcase
  end

  always_comb begin
    ctrl1_n    = wr_c1 ? wdata : ctrl1;
    ctrl2_n    = wr_c2 ? wdata : ctrl2;
    thr_n      = thr;
    thr_full_n = thr_full;
    if (wr_hold) begin
      thr_n      = wdata;
      thr_full_n = 1'b1;
    end else if (echo_load) begin
      thr_n      = rx_data;
      thr_full_n = 1'b1;
    end else if (take) begin
      thr_full_n = 1'b0;
    end
    rbr_n     = rbr;
    rx_full_n = rx_full;
    if (rx_done) begin
      rbr_n     = rx_data;
      rx_full_n = 1'b1;
    end else if (rd_hold) begin
      rx_full_n = 1'b0;
    end
    f_ovr_n = (f_ovr && !rd_stat) || (rx_done && rx_full);
    f_fe_n  = (f_fe  && !rd_stat) || (rx_done && rx_ferr);
    f_pe_n  = (f_pe  && !rd_stat) || (rx_done && rx_perr);
    f_dsc_n = (f_dsc && !rd_stat) || dsc_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1    <= '0;
      ctrl2    <= '0;
      thr      <= '0;
      thr_full <= 1'b0;
      rbr      <= '0;
      rx_full  <= 1'b0;
      f_ovr    <= 1'b0;
      f_fe     <= 1'b0;
      f_pe     <= 1'b0;
      f_dsc    <= 1'b0;
      rx_sync  <= '1;
    end else begin
      ctrl1    <= ctrl1_n;
      ctrl2    <= ctrl2_n;
      thr      <= thr_n;
      thr_full <= thr_full_n;
      rbr      <= rbr_n;
      rx_full  <= rx_full_n;
      f_ovr    <= f_ovr_n;
      f_fe     <= f_fe_n;
      f_pe     <= f_pe_n;
      f_dsc    <= f_dsc_n;
      rx_sync  <= {rx_sync[SYNC-2:0], rxd};
    end
  end
endmodule

// File: rtl/sla_line_ctrl_chk.sv
module sla_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sel,
  input logic       wr,
  input logic       rd,
  input logic [7:0] wdata,
  input logic       txd,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       thr_full,
  input logic       rx_full,
  input logic       rx_done,
  input logic       f_ovr
);
  a_r2_modem_outs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd0) |=> (rts_n == !$past(wdata[1]) && dtr_n == !$past(wdata[0])));

  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd3) |=> thr_full);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == 2'd3 && !rx_done) |=> !rx_full);

  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> f_ovr);

  a_r10_loop_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd0 && !wdata[7]) |=> txd);

  a_r11_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd0 && wdata[7] && wdata[6]) |=> !txd);
endmodule

bind sla_line_ctrl sla_line_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .wdata(wdata),
  .txd(txd), .rts_n(rts_n), .dtr_n(dtr_n), .thr_full(thr_full),
  .rx_full(rx_full), .rx_done(rx_done), .f_ovr(f_ovr)
);

// File: tb/sla_line_ctrl_tb.sv
`timescale 1ns/1ps
module sla_line_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] rate_tick = '0;
  logic       ext_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, rts_n, dtr_n;
  logic       dsr = 1'b0, cd = 1'b0, ri = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] c1_model = 8'h00;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  sla_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .rate_tick(rate_tick), .ext_tick(ext_tick), .rxd(rxd),
    .txd(txd), .rts_n(rts_n), .dtr_n(dtr_n), .dsr(dsr), .cd(cd), .ri(ri)
  );

  // tick sources: rate4 every clock, rate1 every 3, rate2 every 5, rate3 every 7, ext every 2
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rate_tick[0] = (cyc % 3 == 0);
      rate_tick[1] = (cyc % 5 == 0);
      rate_tick[2] = (cyc % 7 == 0);
      rate_tick[3] = 1'b1;
      ext_tick     = (cyc % 2 == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock model of loop mark, break and modem outputs (R10, R11, R2)
  always @(posedge clk) begin
    #3;
    if (mon_on) begin
      if (!c1_model[7]) chk("R10 loop mark", txd, 1);
      else if (c1_model[6]) chk("R11 break", txd, 0);
      chk("R2 rts_n", rts_n, !c1_model[1]);
      chk("R2 dtr_n", dtr_n, !c1_model[0]);
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    sel = s; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1;
    if (s == 2'd0) c1_model = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
    sel = s; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] s, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(s, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic get_frame(input int bp, input int nb, input bit pe,
                           output logic [7:0] d, output logic p,
                           output logic s1, output logic s2);
    int t = 0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk("R3 start bit seen", 0, 1);
    repeat (bp / 2) @(negedge clk);
    d = '0;
    for (int i = 0; i < nb; i++) begin repeat (bp) @(negedge clk); d[i] = txd; end
    p = 1'b0;
    if (pe) begin repeat (bp) @(negedge clk); p = txd; end
    repeat (bp) @(negedge clk); s1 = txd;
    repeat (bp) @(negedge clk); s2 = txd;
  endtask

  task automatic put_frame(input int bp, input int nb, input logic [7:0] d,
                           input bit pe, input bit pb, input bit stop_ok);
    rxd = 1'b0; repeat (bp) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (bp) @(negedge clk); end
    if (pe) begin rxd = pb; repeat (bp) @(negedge clk); end
    if (stop_ok) begin
      rxd = 1'b1;
    end else begin
      rxd = 1'b0; repeat (bp * 5 / 8) @(negedge clk); rxd = 1'b1;
    end
    repeat (bp * 2) @(negedge clk);
  endtask

  task automatic frame_chk(input string req, input int bp, input logic [7:0] exp);
    logic [7:0] d; logic p, s1, s2;
    get_frame(bp, 8, 1'b0, d, p, s1, s2);
    chk(req, d, exp);
    chk(req, s1, 1);
  endtask

  initial begin
    logic [7:0] d; logic p, s1, s2, v;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    mon_on = 1'b1;

    // R1 reset state
    rd_chk("R1 ctrl1", 2'd0, 8'h00);
    rd_chk("R1 ctrl2", 2'd1, 8'h00);
    rd_chk("R1 status", 2'd2, 8'h01);
    chk("R1 txd", txd, 1);
    chk("R1 rts_n", rts_n, 1);
    chk("R1 dtr_n", dtr_n, 1);

    // R2 register map and readback
    wr_reg(2'd0, 8'h83);
    rd_chk("R2 ctrl1 readback", 2'd0, 8'h83);
    chk("R2 rts low", rts_n, 0);
    wr_reg(2'd1, 8'h5C);
    rd_chk("R2 ctrl2 readback", 2'd1, 8'h5C);

    // R3 R5 R6: 8 bits, no parity, rate 4
    wr_reg(2'd0, 8'hA4);
    wr_reg(2'd1, 8'h0C);
    fork
      begin get_frame(16, 8, 1'b0, d, p, s1, s2);
            chk("R3 8-bit data", d, 8'hA5); chk("R3 stop", s1, 1); end
      begin wr_reg(2'd3, 8'hA5);
            rd_chk("R5 hold full", 2'd2, 8'h00);
            idle(20);
            rd_chk("R5 empty while sending", 2'd2, 8'h01); end
    join
    idle(60);

    // R4 7 bits even parity
    wr_reg(2'd0, 8'hAC);
    wr_reg(2'd1, 8'h5C);
    fork
      get_frame(16, 7, 1'b1, d, p, s1, s2);
      wr_reg(2'd3, 8'h5B);
    join
    chk("R3 7-bit data", d, 8'h5B);
    chk("R4 even parity", p, 1);
    idle(60);

    // R3 R4 5 bits odd parity, two stop bits, back-to-back
    wr_reg(2'd0, 8'h8C);
    wr_reg(2'd1, 8'hCC);
    fork
      get_frame(16, 5, 1'b1, d, p, s1, s2);
      begin wr_reg(2'd3, 8'h13); wr_reg(2'd3, 8'h0E); end
    join
    chk("R3 5-bit data", d, 8'h13);
    chk("R4 odd parity", p, 0);
    chk("R3 two stop bit 1", s1, 1);
    chk("R3 two stop bit 2", s2, 1);
    idle(200);

    // R3 one stop bit back-to-back: next start follows one stop
    wr_reg(2'd0, 8'hA4);
    fork
      get_frame(16, 5, 1'b0, d, p, s1, s2);
      begin wr_reg(2'd3, 8'h13); wr_reg(2'd3, 8'h0E); end
    join
    chk("R3 one stop", s1, 1);
    chk("R3 next start after one stop", s2, 0);
    idle(200);

    // R6 clock selects
    wr_reg(2'd1, 8'h0D);
    fork frame_chk("R6 rate4/2", 32, 8'h3C); wr_reg(2'd3, 8'h3C); join
    idle(100);
    wr_reg(2'd1, 8'h0F);
    fork frame_chk("R6 rate4/8", 128, 8'hC3); wr_reg(2'd3, 8'hC3); join
    idle(300);
    wr_reg(2'd1, 8'h08);
    fork frame_chk("R6 external", 32, 8'h81); wr_reg(2'd3, 8'h81); join
    idle(100);
    wr_reg(2'd1, 8'h09);
    fork frame_chk("R6 rate1", 48, 8'h66); wr_reg(2'd3, 8'h66); join
    idle(150);

    // R8 receive
    wr_reg(2'd1, 8'h0C);
    put_frame(16, 8, 8'h96, 1'b0, 1'b0, 1'b1);
    rd_chk("R8 rx status", 2'd2, 8'h03);
    rd_chk("R8 rx data", 2'd3, 8'h96);
    rd_chk("R8 rx cleared", 2'd2, 8'h01);

    // R7 receive clock on rate 1 while transmit uses rate 4
    wr_reg(2'd1, 8'h04);
    put_frame(48, 8, 8'h2D, 1'b0, 1'b0, 1'b1);
    rd_chk("R7 rx rate1 data", 2'd3, 8'h2D);

    // R9 overrun
    wr_reg(2'd1, 8'h0C);
    put_frame(16, 8, 8'h11, 1'b0, 1'b0, 1'b1);
    put_frame(16, 8, 8'h22, 1'b0, 1'b0, 1'b1);
    rd_chk("R9 overrun", 2'd2, 8'h07);
    rd_chk("R9 newest kept", 2'd3, 8'h22);
    rd_chk("R9 overrun cleared", 2'd2, 8'h01);

    // R9 framing error
    put_frame(16, 8, 8'h55, 1'b0, 1'b0, 1'b0);
    idle(40);
    rd_chk("R9 framing", 2'd2, 8'h13);
    rd_chk("R9 framing data", 2'd3, 8'h55);
    rd_chk("R9 framing cleared", 2'd2, 8'h01);

    // R9 parity error (even, data 0x01 needs parity 1, send 0)
    wr_reg(2'd0, 8'hAC);
    wr_reg(2'd1, 8'h1C);
    put_frame(16, 8, 8'h01, 1'b1, 1'b0, 1'b1);
    rd_chk("R9 parity", 2'd2, 8'h0B);
    rd_chk("R9 parity data", 2'd3, 8'h01);

    // R10 loopback
    wr_reg(2'd1, 8'h0C);
    wr_reg(2'd0, 8'h24);
    wr_reg(2'd3, 8'h3C);
    idle(250);
    rd_chk("R10 loop received", 2'd2, 8'h03);
    rd_chk("R10 loop data", 2'd3, 8'h3C);

    // R11 break
    wr_reg(2'd0, 8'hC0);
    idle(3);
    chk("R11 break low", txd, 0);
    wr_reg(2'd0, 8'hA4);
    idle(2);
    chk("R11 break released", txd, 1);

    // R12 auto-echo
    wr_reg(2'd0, 8'hB4);
    fork
      put_frame(16, 8, 8'h5A, 1'b0, 1'b0, 1'b1);
      frame_chk("R12 echoed", 16, 8'h5A);
    join
    rd_chk("R12 echo data", 2'd3, 8'h5A);
    idle(100);

    // R13 modem status and data-set change
    wr_reg(2'd0, 8'hA5);
    rd_reg(2'd2, v);
    dsr = 1'b1; idle(10);
    rd_chk("R13 dsr change with dtr", 2'd2, 8'hC1);
    rd_chk("R13 change cleared", 2'd2, 8'h41);
    wr_reg(2'd0, 8'hA4);
    rd_reg(2'd2, v);
    cd = 1'b1; idle(10);
    rd_chk("R13 cd ignored without dtr", 2'd2, 8'h61);
    ri = 1'b1; idle(10);
    rd_chk("R13 ri change without dtr", 2'd2, 8'hE1);

    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule